// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two packed 32-bit floating-point numbers. Each number has a sign bit (0 means positive), an 8-bit exponent stored with a bias of 127, and a 23-bit fraction below an implied leading 1. The unit picks the operand with the larger magnitude and shifts the other mantissa right until the exponents match. It then adds or subtracts the mantissas, normalizes the result in either direction and packs the result fields. No rounding is done: mantissa bits that move below the 23-bit fraction are dropped.

The datapath is combinational and ends in one output register, so a result appears one clock after its operands are presented. A new operation can start on every cycle. Subnormal inputs are read as zero. An all-ones exponent is passed through unchanged, with no further handling of infinity or NaN. No flags are raised.

Top module: `fp_addsub`

## Requirements
- R1: While `rst` is high, `result` is cleared to 0 at each rising clock edge. Otherwise, `result` holds the outcome for the `op_a`, `op_b` and `sub` values sampled at the previous rising edge.
- R2: Bit 31 is the sign, bits 30:23 are the biased exponent and bits 22:0 are the fraction. When `sub` is 0, the block computes A+B after shifting the smaller-exponent mantissa right by the exponent difference. For example, 0x42B00000 + 0x41D00000 gives 0x42E40000.
- R3: When `sub` is 1, the sign of B is inverted before the operation. If the effective signs differ, the smaller magnitude is subtracted from the larger magnitude. The result takes the sign of the larger-magnitude operand, and A counts as the larger when the magnitudes are equal.
- R4: If the mantissa sum carries past the leading bit position, the mantissa is shifted right by one and the exponent is raised by one.
- R5: After a subtraction, the mantissa is shifted left until its leading 1 is back in the hidden-bit position, and the exponent is lowered by the same count.
- R6: A zero mantissa result is encoded as 0x00000000 (positive sign) for every input sign combination.
- R7: If the exponent reaches 255 while the result is being normalized, the output is infinity with the result sign: exponent 255 and fraction 0.
- R8: Bits of the aligned smaller mantissa that fall below the least significant fraction bit are discarded. A shift of 24 or more positions reduces that mantissa to zero.
- R9: An operand whose exponent field is 0 counts as zero, whatever its fraction bits hold.
- R10: If A's exponent field is 255, the output is A unchanged. Otherwise, if B's exponent field is 255, the output is B with its sign inverted when `sub` is 1.
- R11: If left normalization would bring the exponent to 0 or below, the output is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | Operand A, packed single-precision value |
| op_b | input | 32 | Operand B, packed single-precision value |
| sub | input | 1 | 0 selects A+B, 1 selects A-B |
| result | output | 32 | Registered, truncated result |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. Those widths give the standard single-precision encodings, so the worked example and common values such as 1.0, 2.0 and 3.0 can be checked bit for bit. They also bring the edge exponents 1 and 254 into directed tests, which reach overflow to infinity and underflow to zero. Exponent gaps of 23, 24 and 30 probe the truncation boundary. Randomized operand pairs with exponent gaps of up to 30 positions are compared against a behavioural integer model of the truncating algorithm.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fp_op_e;
endpackage

// File: rtl/fp_addsub_lzc.sv
module fp_addsub_lzc #(
  parameter int WIDTH = 24,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] zeros
);
  // highest set bit wins because later iterations overwrite earlier ones
  always_comb begin
    zeros = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) zeros = CNT_W'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/fp_addsub_align.sv
module fp_addsub_align
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MW     = FRAC_W + 1
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  fp_op_e                op,
  output logic                  big_sign,
  output logic [EXP_W-1:0]      big_exp,
  output logic [MW-1:0]         big_mant,
  output logic [MW-1:0]         small_mant,
  output logic                  eff_sub,
  output logic                  special,
  output logic [EXP_W+FRAC_W:0] special_val
);
  localparam int MAGW = EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EMAX = '1;

  logic             sign_a, sign_b, b_bigger;
  logic [EXP_W-1:0] exp_a, exp_b, small_exp, gap;
  logic [MW-1:0]    mant_a, mant_b, small_raw;

  assign sign_a = a[MAGW];
  assign sign_b = b[MAGW] ^ (op == OP_SUB);
  assign exp_a  = a[MAGW-1:FRAC_W];
  assign exp_b  = b[MAGW-1:FRAC_W];
  // zero exponent field means the operand is zero
  assign mant_a = (exp_a != '0) ? {1'b1, a[FRAC_W-1:0]} : '0;
  assign mant_b = (exp_b != '0) ? {1'b1, b[FRAC_W-1:0]} : '0;
  assign b_bigger = b[MAGW-1:0] > a[MAGW-1:0];

  always_comb begin
    if (b_bigger) begin
      big_sign  = sign_b;
      big_exp   = exp_b;
      big_mant  = mant_b;
      small_exp = exp_a;
      small_raw = mant_a;
    end else begin
      big_sign  = sign_a;
      big_exp   = exp_a;
      big_mant  = mant_a;
      small_exp = exp_b;
      small_raw = mant_b;
    end
  end

  assign gap        = big_exp - small_exp;
  assign small_mant = small_raw >> gap;
  assign eff_sub    = sign_a ^ sign_b;

  always_comb begin
    special     = 1'b0;
    special_val = '0;
    if (exp_a == EMAX) begin
      special     = 1'b1;
      special_val = a;
    end else if (exp_b == EMAX) begin
      special     = 1'b1;
      special_val = {sign_b, b[MAGW-1:0]};
    end
  end
endmodule

// File: rtl/fp_addsub_norm.sv
module fp_addsub_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MW     = FRAC_W + 1
) (
  input  logic                  big_sign,
  input  logic [EXP_W-1:0]      big_exp,
  input  logic [MW-1:0]         big_mant,
  input  logic [MW-1:0]         small_mant,
  input  logic                  eff_sub,
  input  logic                  special,
  input  logic [EXP_W+FRAC_W:0] special_val,
  output logic [EXP_W+FRAC_W:0] res
);
  localparam int LZ_W = $clog2(MW + 1);
  localparam logic [EXP_W-1:0] EMAX = '1;

  logic [MW:0]         sum;
  logic [LZ_W-1:0]     lz;
  logic [EXP_W:0]      exp_up;
  logic [FRAC_W-1:0]   frac_left;

  assign sum = eff_sub ? ({1'b0, big_mant} - {1'b0, small_mant})
                       : ({1'b0, big_mant} + {1'b0, small_mant});

  fp_addsub_lzc #(.WIDTH(MW), .CNT_W(LZ_W)) u_lzc (
    .vec   (sum[MW-1:0]),
    .zeros (lz)
  );

  assign exp_up    = {1'b0, big_exp} + (EXP_W+1)'(1);
  assign frac_left = FRAC_W'(sum[FRAC_W-1:0] << lz);

  always_comb begin
    res = '0;
    if (special) begin
      res = special_val;
    end else if (sum == '0) begin
      res = '0;
    end else if (sum[MW]) begin
      if (exp_up >= {1'b0, EMAX}) res = {big_sign, EMAX, {FRAC_W{1'b0}}};
      else                        res = {big_sign, exp_up[EXP_W-1:0], sum[FRAC_W:1]};
    end else if ({1'b0, big_exp} <= (EXP_W+1)'(lz)) begin
      res = '0;
    end else begin
      res = {big_sign, big_exp - EXP_W'(lz), frac_left};
    end
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  sub,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int MW = FRAC_W + 1;

  fp_op_e                op;
  logic                  big_sign, eff_sub, special;
  logic [EXP_W-1:0]      big_exp;
  logic [MW-1:0]         big_mant, small_mant;
  logic [EXP_W+FRAC_W:0] special_val, res_d;

  assign op = sub ? OP_SUB : OP_ADD;

  fp_addsub_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .MW(MW)) u_align (
    .a           (op_a),
    .b           (op_b),
    .op          (op),
    .big_sign    (big_sign),
    .big_exp     (big_exp),
    .big_mant    (big_mant),
    .small_mant  (small_mant),
    .eff_sub     (eff_sub),
    .special     (special),
    .special_val (special_val)
  );

  fp_addsub_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .MW(MW)) u_norm (
    .big_sign    (big_sign),
    .big_exp     (big_exp),
    .big_mant    (big_mant),
    .small_mant  (small_mant),
    .eff_sub     (eff_sub),
    .special     (special),
    .special_val (special_val),
    .res         (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= res_d;
  end
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  sub,
  input logic [EXP_W+FRAC_W:0] result
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [EXP_W-1:0] EMAX = '1;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (result == '0)); // R1

  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    (result[W-2:0] == '0) |-> !result[W-1]); // R6

  AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sub) && ($past(op_a) == $past(op_b)) &&
     ($past(op_a[W-2:FRAC_W]) != EMAX)) |-> (result == '0)); // R3

  AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_a[W-2:FRAC_W]) == EMAX)) |-> (result == $past(op_a))); // R10

  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (rst)
    (result[W-2:FRAC_W] == '0) |-> (result[FRAC_W-1:0] == '0)); // R11

  AST_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(sub) && ($past(op_b[W-2:FRAC_W]) == '0) &&
     ($past(op_a[W-2:FRAC_W]) != '0) && ($past(op_a[W-2:FRAC_W]) != EMAX))
    |-> (result == $past(op_a))); // R9
endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .sub    (sub),
  .result (result)
);

// File: tb/fp_addsub_test.sv
`timescale 1ns/1ps
module fp_addsub_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sub = 1'b0;
  logic [31:0] result;
  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_addsub uut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub(sub), .result(result));

  // truncating behavioural model written from the requirements
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
    int ea, eb, e1, e2, e, d;
    longint m1, m2, r, ma, mb;
    logic sa, sb, s1, s2;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    sa = a[31]; sb = b[31] ^ s;
    if (ea == 255) return a;
    if (eb == 255) return {sb, b[30:0]};
    ma = (ea != 0) ? (longint'(1) << 23) + longint'(a[22:0]) : 0;
    mb = (eb != 0) ? (longint'(1) << 23) + longint'(b[22:0]) : 0;
    if (b[30:0] > a[30:0]) begin
      e1 = eb; m1 = mb; s1 = sb; e2 = ea; m2 = ma; s2 = sa;
    end else begin
      e1 = ea; m1 = ma; s1 = sa; e2 = eb; m2 = mb; s2 = sb;
    end
    d = e1 - e2;
    m2 = (d >= 32) ? 0 : (m2 >> d);
    r = (s1 == s2) ? m1 + m2 : m1 - m2;
    if (r == 0) return 32'h0;
    e = e1;
    while (r >= (longint'(1) << 24)) begin r = r >> 1; e++; end
    while (r < (longint'(1) << 23)) begin r = r << 1; e--; end
    if (e >= 255) return {s1, 8'hFF, 23'h0};
    if (e <= 0) return 32'h0;
    return {s1, 8'(e), 23'(r)};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s, input string req,
                       input logic [31:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; sub = s;
    @(negedge clk);
    check(req, result, exp);
  endtask

  task automatic t_reset();
    op_a = 32'h3F800000; op_b = 32'h3F800000; sub = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset clear", result, 32'h0);
    rst = 1'b0;
    apply(32'h3F800000, 32'h40000000, 1'b0, "R1 one-cycle latency", 32'h40400000);
  endtask

  task automatic t_align_example();
    apply(32'h42B00000, 32'h41D00000, 1'b0, "R2 aligned add", 32'h42E40000);
    apply(32'h41D00000, 32'h42B00000, 1'b0, "R2 swapped order", 32'h42E40000);
  endtask

  task automatic t_subtract();
    apply(32'h40400000, 32'h3F800000, 1'b1, "R3 3-1", 32'h40000000);
    apply(32'h3F800000, 32'h40400000, 1'b1, "R3 sign of larger", 32'hC0000000);
    apply(32'hC0400000, 32'h3F800000, 1'b0, "R3 mixed signs add", 32'hC0000000);
  endtask

  task automatic t_carry();
    apply(32'h3F800000, 32'h3F800000, 1'b0, "R4 1+1", 32'h40000000);
    apply(32'h3FC00000, 32'h3FC00000, 1'b0, "R4 1.5+1.5", 32'h40400000);
  endtask

  task automatic t_left_norm();
    apply(32'h3FC00000, 32'h3FA00000, 1'b1, "R5 1.5-1.25", 32'h3E800000);
    apply(32'h3F800001, 32'h3F800000, 1'b1, "R5 deep cancel", 32'h34000000);
  endtask

  task automatic t_exact_zero();
    apply(32'h40A00000, 32'h40A00000, 1'b1, "R6 x-x", 32'h00000000);
    apply(32'hC0000000, 32'h40000000, 1'b0, "R6 -2+2", 32'h00000000);
    apply(32'h80000000, 32'h80000000, 1'b0, "R6 -0+-0", 32'h00000000);
  endtask

  task automatic t_overflow();
    apply(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R7 positive overflow", 32'h7F800000);
    apply(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R7 negative overflow", 32'hFF800000);
  endtask

  task automatic t_gap();
    apply(32'h3F800000, 32'h34000000, 1'b0, "R8 gap 23 kept", 32'h3F800001);
    apply(32'h3F800000, 32'h33FFFFFF, 1'b0, "R8 gap 24 dropped", 32'h3F800000);
    apply(32'h3F800000, 32'h30800000, 1'b0, "R8 gap 30 dropped", 32'h3F800000);
    apply(32'h3F800000, 32'h33800000, 1'b1, "R8 sub gap 24", 32'h3F800000);
  endtask

  task automatic t_zero_operand();
    apply(32'h40490FDB, 32'h00000000, 1'b0, "R9 plus zero", 32'h40490FDB);
    apply(32'h40490FDB, 32'h007FFFFF, 1'b1, "R9 subnormal as zero", 32'h40490FDB);
    apply(32'h00000000, 32'h3F800000, 1'b1, "R9 zero minus one", 32'hBF800000);
  endtask

  task automatic t_special();
    apply(32'h7FC00000, 32'h3F800000, 1'b0, "R10 A passes", 32'h7FC00000);
    apply(32'h3F800000, 32'h7F800000, 1'b1, "R10 B passes negated", 32'hFF800000);
    apply(32'hFF800000, 32'h7F800000, 1'b0, "R10 A first", 32'hFF800000);
  endtask

  task automatic t_underflow();
    apply(32'h00800001, 32'h00800000, 1'b1, "R11 flush", 32'h00000000);
    apply(32'h00C00000, 32'h00800000, 1'b1, "R11 flush at exp 0", 32'h00000000);
    apply(32'h01400000, 32'h01000000, 1'b1, "R11 stays at exp 1", 32'h00800000);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic s;
      int ea, eb;
      ea = 100 + int'($urandom % 60);
      eb = ea + int'($urandom % 61) - 30;
      a = {1'($urandom), 8'(ea), 23'($urandom)};
      b = {1'($urandom), 8'(eb), 23'($urandom)};
      s = 1'($urandom);
      apply(a, b, s, "R2 random vs model", model(a, b, s));
    end
  endtask

  initial begin
    t_reset();
    t_align_example();
    t_subtract();
    t_carry();
    t_left_norm();
    t_exact_zero();
    t_overflow();
    t_gap();
    t_zero_operand();
    t_special();
    t_underflow();
    t_random();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule